// File: doc/BRIEF.md
# Speculative Command Staging Interface

This block sits between a processor's register bus and two message streams. The processor writes command words into a staging bank before it knows whether they will be needed. Nothing leaves the block until the processor writes the release register. A release moves the whole staged batch onto the outgoing command stream, oldest word first. If the awaited event turns out different from what was predicted, a write to the discard register throws the staged batch away and nothing is transmitted. Each command word carries a destination field in its top bits so that a downstream switch can route it.

There are two staging banks. While one bank drains onto the command stream, new writes go into the other bank, so the processor can prepare the next batch without waiting. Response messages coming back from the components are queued in a response FIFO. The processor pops them by reading the response register. A status register reports the staged count, the response count, whether a batch is draining, and two sticky error bits.

Top module: `msg_stage_if`

## Requirements
- R1: After reset, `cmd_valid_o` is 0, `rsp_ready_o` is 1 and a read of the status register (address 4) returns 0.
- R2: A write to address 0 stages its 32-bit word in the filling bank without transmitting it. Status bits [7:0] give the filling bank's word count.
- R3: A write to address 0 while the filling bank holds CMD_DEPTH words is dropped and sets a sticky overflow flag, which is status bit 17. Writing status with bit 17 set clears the flag.
- R4: A write to address 1 (release), when no batch is draining and the filling bank is not empty, sends every staged word in write order. Each word is split into `cmd_dest_o` = word[31:28] and `cmd_payload_o` = word[27:0]. While `cmd_ready_i` is low, the valid word and its fields hold steady.
- R5: While a batch drains, status bit 16 is 1. Writes to address 0 go to the other bank and are not sent. A release in that time is ignored, so those writes wait for a later release.
- R6: A write to address 2 (discard) empties the filling bank without sending any of it. A batch that is already draining is unaffected.
- R7: Responses are accepted on `rsp_valid_i` while `rsp_ready_o` is 1. `rsp_ready_o` is 0 when RSP_DEPTH responses are queued. Status bits [15:8] give the queued count. A read of address 3 pops the oldest response, which appears on `reg_rdata_o` one cycle after the read strobe.
- R8: A read of address 3 with no response queued returns 0 and sets a sticky underflow flag, which is status bit 18. Writing status with bit 18 set clears the flag.
- R9: When a response arrives in the same cycle as a read of address 3, the read sees the queue as it stood before that cycle, and the arriving response is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data, registered one cycle after the strobe |
| cmd_valid_o | output | 1 | Command word valid |
| cmd_ready_i | input | 1 | Command sink ready |
| cmd_dest_o | output | DEST_W | Destination field of the command word |
| cmd_payload_o | output | PAY_W | Payload field of the command word |
| rsp_valid_i | input | 1 | Response valid |
| rsp_ready_o | output | 1 | Response queue has room |
| rsp_data_i | input | RSP_W | Response word |

## Verification
Two functions can fall in the same cycle: a response arriving on the stream and the processor reading the response register. The bench drives both strobes into the same clock edge, once with the queue empty and once with one response already queued. With the queue empty, the read must return 0 and raise the underflow flag, and the next read must return the response that arrived. With one response queued, the read must return the older response and the newer one must follow on the next read. A scoreboard holds the commands expected on the outgoing stream. Any word that appears before a release, after a discard, or out of order shows up as a mismatch.

// File: rtl/msg_stage_pkg.sv
package msg_stage_pkg;
  typedef enum logic [2:0] {
    ADDR_CMD  = 3'd0,
    ADDR_GO   = 3'd1,
    ADDR_DROP = 3'd2,
    ADDR_RSP  = 3'd3,
    ADDR_STAT = 3'd4
  } reg_addr_e;

  localparam int unsigned STAT_BUSY_BIT = 16;
  localparam int unsigned STAT_OVF_BIT  = 17;
  localparam int unsigned STAT_UDF_BIT  = 18;
endpackage

// File: rtl/msg_stage_fifo.sv
module msg_stage_fifo #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned PW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [W-1:0]  data_i,
  input  logic          pop_i,
  output logic [W-1:0]  data_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o && !flush_i;
  assign do_pop  = pop_i && !empty_o && !flush_i;
  assign data_o  = mem[rptr_q];
  assign count_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else if (flush_i) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_push) wptr_q <= PW'(wptr_q + 1'b1);
      if (do_pop)  rptr_q <= PW'(rptr_q + 1'b1);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wptr_q] <= data_i;
  end
endmodule

// File: rtl/msg_stage_banks.sv
module msg_stage_banks #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          stage_i,
  input  logic [W-1:0]  stage_data_i,
  input  logic          release_i,
  input  logic          discard_i,
  output logic          out_valid_o,
  input  logic          out_ready_i,
  output logic [W-1:0]  out_data_o,
  output logic [CW-1:0] fill_cnt_o,
  output logic          fill_full_o,
  output logic          draining_o
);
  logic          fill_sel_q;
  logic [W-1:0]  head  [2];
  logic [CW-1:0] cnt   [2];
  logic          full  [2];
  logic          empty [2];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    msg_stage_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .flush_i (discard_i && (fill_sel_q == 1'(b))),
      .push_i  (stage_i && (fill_sel_q == 1'(b))),
      .data_i  (stage_data_i),
      .pop_i   (out_ready_i && (fill_sel_q != 1'(b))),
      .data_o  (head[b]),
      .count_o (cnt[b]),
      .full_o  (full[b]),
      .empty_o (empty[b])
    );
  end

  logic drain_sel;
  assign drain_sel   = ~fill_sel_q;
  assign draining_o  = !empty[drain_sel];
  assign out_valid_o = draining_o;
  assign out_data_o  = head[drain_sel];
  assign fill_cnt_o  = cnt[fill_sel_q];
  assign fill_full_o = full[fill_sel_q];

  // swap roles only when the previous batch is fully out
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fill_sel_q <= 1'b0;
    else if (release_i && empty[drain_sel] && !empty[fill_sel_q])
      fill_sel_q <= ~fill_sel_q;
  end
endmodule

// File: rtl/msg_stage_if.sv
module msg_stage_if
  import msg_stage_pkg::*;
#(
  parameter int unsigned DEST_W    = 4,
  parameter int unsigned PAY_W     = 28,
  parameter int unsigned CMD_DEPTH = 8,
  parameter int unsigned RSP_DEPTH = 4,
  parameter int unsigned RSP_W     = 32,
  localparam int unsigned CMD_W    = DEST_W + PAY_W,
  localparam int unsigned CCW      = $clog2(CMD_DEPTH + 1),
  localparam int unsigned RCW      = $clog2(RSP_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              cmd_valid_o,
  input  logic              cmd_ready_i,
  output logic [DEST_W-1:0] cmd_dest_o,
  output logic [PAY_W-1:0]  cmd_payload_o,
  input  logic              rsp_valid_i,
  output logic              rsp_ready_o,
  input  logic [RSP_W-1:0]  rsp_data_i
);
  logic             cmd_wr, go_wr, drop_wr, stat_wr, rsp_rd;
  logic [CCW-1:0]   fill_cnt;
  logic             fill_full, draining;
  logic [CMD_W-1:0] out_word;
  logic [RSP_W-1:0] rsp_head;
  logic [RCW-1:0]   rsp_cnt;
  logic             rsp_full, rsp_empty;
  logic             ovf_q, udf_q;
  logic [31:0]      status_w;

  assign cmd_wr  = reg_we_i && (reg_addr_i == ADDR_CMD);
  assign go_wr   = reg_we_i && (reg_addr_i == ADDR_GO);
  assign drop_wr = reg_we_i && (reg_addr_i == ADDR_DROP);
  assign stat_wr = reg_we_i && (reg_addr_i == ADDR_STAT);
  assign rsp_rd  = reg_re_i && (reg_addr_i == ADDR_RSP);

  msg_stage_banks #(.W(CMD_W), .DEPTH(CMD_DEPTH)) u_banks (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .stage_i      (cmd_wr),
    .stage_data_i (reg_wdata_i[CMD_W-1:0]),
    .release_i    (go_wr),
    .discard_i    (drop_wr),
    .out_valid_o  (cmd_valid_o),
    .out_ready_i  (cmd_ready_i),
    .out_data_o   (out_word),
    .fill_cnt_o   (fill_cnt),
    .fill_full_o  (fill_full),
    .draining_o   (draining)
  );

  assign cmd_dest_o    = out_word[CMD_W-1 -: DEST_W];
  assign cmd_payload_o = out_word[PAY_W-1:0];

  msg_stage_fifo #(.W(RSP_W), .DEPTH(RSP_DEPTH)) u_rsp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (1'b0),
    .push_i  (rsp_valid_i),
    .data_i  (rsp_data_i),
    .pop_i   (rsp_rd),
    .data_o  (rsp_head),
    .count_o (rsp_cnt),
    .full_o  (rsp_full),
    .empty_o (rsp_empty)
  );
  assign rsp_ready_o = !rsp_full;

  always_comb begin
    status_w                = '0;
    status_w[7:0]           = 8'(fill_cnt);
    status_w[15:8]          = 8'(rsp_cnt);
    status_w[STAT_BUSY_BIT] = draining;
    status_w[STAT_OVF_BIT]  = ovf_q;
    status_w[STAT_UDF_BIT]  = udf_q;
  end

  // sticky flags: a set in the same cycle wins over a clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_q <= 1'b0;
      udf_q <= 1'b0;
    end else begin
      ovf_q <= (cmd_wr && fill_full) ||
               (ovf_q && !(stat_wr && reg_wdata_i[STAT_OVF_BIT]));
      udf_q <= (rsp_rd && rsp_empty) ||
               (udf_q && !(stat_wr && reg_wdata_i[STAT_UDF_BIT]));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) reg_rdata_o <= '0;
    else if (reg_re_i) begin
      case (reg_addr_i)
        ADDR_RSP:  reg_rdata_o <= rsp_empty ? '0 : 32'(rsp_head);
        ADDR_STAT: reg_rdata_o <= status_w;
        default:   reg_rdata_o <= '0;
      endcase
    end
  end
endmodule

// File: rtl/msg_stage_if_chk.sv
module msg_stage_if_chk #(
  parameter int unsigned DEST_W    = 4,
  parameter int unsigned PAY_W     = 28,
  parameter int unsigned CMD_DEPTH = 8,
  parameter int unsigned RSP_DEPTH = 4,
  parameter int unsigned CCW       = 4,
  parameter int unsigned RCW       = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic              reg_re_i,
  input logic [2:0]        reg_addr_i,
  input logic [31:0]       reg_wdata_i,
  input logic [31:0]       reg_rdata_o,
  input logic              cmd_valid_o,
  input logic              cmd_ready_i,
  input logic [DEST_W-1:0] cmd_dest_o,
  input logic [PAY_W-1:0]  cmd_payload_o,
  input logic              rsp_ready_o,
  input logic [CCW-1:0]    fill_cnt,
  input logic              draining,
  input logic [RCW-1:0]    rsp_cnt,
  input logic              ovf_q,
  input logic              udf_q
);
  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_dest_o) && $stable(cmd_payload_o));

  assert_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !draining |-> !cmd_valid_o);

  assert_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i && reg_addr_i == 3'd0 && fill_cnt == CCW'(CMD_DEPTH) |=> ovf_q && $stable(fill_cnt));

  assert_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q && !(reg_we_i && reg_addr_i == 3'd4 && reg_wdata_i[17]) |=> ovf_q);

  assert_discard_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i && reg_addr_i == 3'd2 |=> fill_cnt == '0);

  assert_full_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_cnt == RCW'(RSP_DEPTH) |-> !rsp_ready_o);

  assert_underflow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_re_i && reg_addr_i == 3'd3 && rsp_cnt == '0 |=> udf_q && reg_rdata_o == '0);
endmodule

bind msg_stage_if msg_stage_if_chk #(
  .DEST_W(DEST_W), .PAY_W(PAY_W), .CMD_DEPTH(CMD_DEPTH),
  .RSP_DEPTH(RSP_DEPTH), .CCW(CCW), .RCW(RCW)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_re_i(reg_re_i),
  .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
  .cmd_valid_o(cmd_valid_o), .cmd_ready_i(cmd_ready_i), .cmd_dest_o(cmd_dest_o),
  .cmd_payload_o(cmd_payload_o), .rsp_ready_o(rsp_ready_o), .fill_cnt(fill_cnt),
  .draining(draining), .rsp_cnt(rsp_cnt), .ovf_q(ovf_q), .udf_q(udf_q)
);

// File: tb/msg_stage_if_test.sv
module msg_stage_if_test;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0, re = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        cmd_valid, cmd_ready = 1'b1;
  logic [3:0]  cmd_dest;
  logic [27:0] cmd_payload;
  logic        rsp_valid = 1'b0, rsp_ready;
  logic [31:0] rsp_data = '0;

  int checks = 0, failures = 0;
  logic [31:0] exp_q[$];
  logic [31:0] staged_q[$];

  always #10 clk = ~clk;

  msg_stage_if uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_re_i(re), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .cmd_valid_o(cmd_valid),
    .cmd_ready_i(cmd_ready), .cmd_dest_o(cmd_dest), .cmd_payload_o(cmd_payload),
    .rsp_valid_i(rsp_valid), .rsp_ready_o(rsp_ready), .rsp_data_i(rsp_data)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    @(posedge clk); #1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1; we = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
    @(posedge clk); #1; re = 1'b1; addr = a;
    @(posedge clk); #1; re = 1'b0; d = rdata;
  endtask

  task automatic stage(input logic [31:0] w);
    if (staged_q.size() < DEPTH) staged_q.push_back(w);
    reg_write(3'd0, w);
  endtask

  // driver: an accepted release hands the staged batch to the scoreboard
  task automatic release_batch();
    if (exp_q.size() == 0 && staged_q.size() > 0) begin
      foreach (staged_q[i]) exp_q.push_back(staged_q[i]);
      staged_q.delete();
    end
    reg_write(3'd1, 32'h0);
  endtask

  task automatic discard();
    staged_q.delete();
    reg_write(3'd2, 32'h0);
  endtask

  task automatic push_rsp(input logic [31:0] d);
    @(posedge clk); #1; rsp_valid = 1'b1; rsp_data = d;
    @(posedge clk); #1; rsp_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_status(input logic [31:0] exp, input string req);
    logic [31:0] v;
    reg_read(3'd4, v);
    chk(v == exp, req, v, exp);
  endtask

  // monitor: compares every handshake against the scoreboard, and checks hold on stall (R4)
  logic        stalled = 1'b0;
  logic [31:0] stall_word = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (stalled)
        chk(cmd_valid && {cmd_dest, cmd_payload} == stall_word, "R4 hold", {cmd_dest, cmd_payload}, stall_word);
      if (cmd_valid && cmd_ready) begin
        if (exp_q.size() == 0)
          chk(1'b0, "R2/R6 unexpected command", {cmd_dest, cmd_payload}, 32'h0);
        else begin
          logic [31:0] e;
          e = exp_q.pop_front();
          chk({cmd_dest, cmd_payload} == e, "R4 order/fields", {cmd_dest, cmd_payload}, e);
        end
      end
      stalled = cmd_valid && !cmd_ready;
      stall_word = {cmd_dest, cmd_payload};
    end
  end

  initial begin
    #4_000_000;
    failures++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] v;
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1
    chk(cmd_valid == 1'b0, "R1 cmd_valid", 32'(cmd_valid), 32'h0);
    chk(rsp_ready == 1'b1, "R1 rsp_ready", 32'(rsp_ready), 32'h1);
    expect_status(32'h0, "R1 status");

    // R2 staging holds, R4 release in order
    stage(32'h1000_0001); stage(32'h2000_0002); stage(32'hF123_4567);
    idle(5);
    expect_status(32'd3, "R2 staged count");
    release_batch();
    idle(10);
    chk(exp_q.size() == 0, "R4 batch drained", exp_q.size(), 32'h0);
    expect_status(32'h0, "R4 status after drain");

    // R5 second bank while draining, release ignored while busy
    cmd_ready = 1'b0;
    stage(32'hA000_00A1); stage(32'hB000_00B2);
    release_batch();
    stage(32'hC000_00C3); stage(32'hD000_00D4);
    release_batch();
    expect_status(32'd2 | (32'd1 << 16), "R5 busy with second bank");
    cmd_ready = 1'b1;
    idle(10);
    chk(exp_q.size() == 0, "R5 first batch only", exp_q.size(), 32'h0);
    expect_status(32'd2, "R5 second bank kept");
    release_batch();
    idle(10);
    chk(exp_q.size() == 0, "R5 second batch sent", exp_q.size(), 32'h0);

    // R6 discard
    stage(32'h1111_1111); stage(32'h2222_2222); stage(32'h3333_3333);
    discard();
    expect_status(32'h0, "R6 discard empties");
    release_batch();
    idle(8);
    chk(exp_q.size() == 0, "R6 nothing sent", exp_q.size(), 32'h0);
    cmd_ready = 1'b0;
    stage(32'h4444_4444); stage(32'h5555_5555);
    release_batch();
    stage(32'h6666_6666);
    discard();
    cmd_ready = 1'b1;
    idle(10);
    chk(exp_q.size() == 0, "R6 draining batch intact", exp_q.size(), 32'h0);
    expect_status(32'h0, "R6 status");

    // R3 overflow
    for (int i = 0; i < DEPTH + 1; i++) stage(32'h7000_0000 + 32'(i));
    expect_status(32'd8 | (32'd1 << 17), "R3 overflow set");
    reg_write(3'd4, 32'd1 << 17);
    expect_status(32'd8, "R3 overflow cleared");
    release_batch();
    idle(15);
    chk(exp_q.size() == 0, "R3 kept words sent", exp_q.size(), 32'h0);

    // R7 responses
    push_rsp(32'h11); push_rsp(32'h22); push_rsp(32'h33); push_rsp(32'h44);
    chk(rsp_ready == 1'b0, "R7 full backpressure", 32'(rsp_ready), 32'h0);
    expect_status(32'd4 << 8, "R7 response count");
    for (int i = 0; i < 4; i++) begin
      reg_read(3'd3, v);
      chk(v == 32'h11 * 32'(i + 1), "R7 response order", v, 32'h11 * 32'(i + 1));
    end

    // R8 underflow
    reg_read(3'd3, v);
    chk(v == 32'h0, "R8 empty read zero", v, 32'h0);
    expect_status(32'd1 << 18, "R8 underflow set");
    reg_write(3'd4, 32'd1 << 18);
    expect_status(32'h0, "R8 underflow cleared");

    // R9 arrival and read in the same cycle
    @(posedge clk); #1; rsp_valid = 1'b1; rsp_data = 32'h55; re = 1'b1; addr = 3'd3;
    @(posedge clk); #1; rsp_valid = 1'b0; re = 1'b0; v = rdata;
    chk(v == 32'h0, "R9 empty queue read", v, 32'h0);
    reg_read(3'd3, v);
    chk(v == 32'h55, "R9 arrival kept", v, 32'h55);
    reg_write(3'd4, 32'd1 << 18);
    push_rsp(32'h66);
    @(posedge clk); #1; rsp_valid = 1'b1; rsp_data = 32'h77; re = 1'b1; addr = 3'd3;
    @(posedge clk); #1; rsp_valid = 1'b0; re = 1'b0; v = rdata;
    chk(v == 32'h66, "R9 older first", v, 32'h66);
    reg_read(3'd3, v);
    chk(v == 32'h77, "R9 newer next", v, 32'h77);
    expect_status(32'h0, "R9 final status");

    chk(exp_q.size() == 0, "R4 scoreboard empty", exp_q.size(), 32'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule